// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. In the same cycle it takes two operands, a 5-bit operation code and the current status byte. The second operand may come from the register file or from an immediate field; that choice is made upstream. It produces the result and a result write strobe combinationally, and loads an updated status byte into its own register on the next clock edge.

Each operation updates only its own subset of the status flags. Every other flag is copied from `status_in`, so the caller can feed `status_q` back into `status_in` to keep one architectural status register. Compare operations produce flags and no write. The carry-chained subtract and compare keep the zero flag sticky, so that multi-byte comparisons chain correctly.

Status layout used everywhere: bit 0 carry C, bit 1 zero Z, bit 2 negative N, bit 3 overflow V, bit 4 sign S, bit 5 half-carry H. Bits 6 and 7 are never computed and are copied from `status_in`.

Top module: `alu8_core`

## Requirements
- R1: Opcodes ADD=0 and ADC=1 give a+b (ADC adds incoming C). C is the carry out of bit 7, H is the carry out of bit 3, and V is set when both operands share a sign that the result lacks.
- R2: Opcodes SUB=2 and SBC=3 give a-b (SBC also subtracts incoming C). C is the borrow out of bit 7, H is the borrow into bit 4, and V is set when the operand signs differ and the result sign differs from a.
- R3: Opcodes CP=4 and CPC=5 set flags exactly as SUB and SBC do but keep result_we low. Every other defined opcode raises result_we while op_en is high.
- R4: For SBC and CPC, Z is 1 only when the result is zero and incoming Z was 1. A nonzero result clears Z.
- R5: Opcodes AND=6, OR=7 and XOR=8 update Z and N, force V to 0 and leave C and H unchanged.
- R6: Opcode COM=9 gives 0xFF-a, sets C to 1, clears V and leaves H unchanged. Opcode NEG=10 gives 0x00-a and updates all six flags as a subtraction from zero.
- R7: Opcodes INC=11 and DEC=12 add or subtract 1 and set V on signed wrap (0x7F to 0x80, or 0x80 to 0x7F). C and H stay unchanged.
- R8: Opcodes LSL=13 and ROL=14 shift left, with ROL moving incoming C into bit 0. Old bit 7 goes to C and old bit 3 goes to H.
- R9: Opcodes LSR=15, ROR=16 and ASR=17 shift right. The incoming bit 7 is 0 for LSR, incoming C for ROR, and old bit 7 for ASR. Old bit 0 goes to C and H is unchanged.
- R10: For all shifts and rotates, V equals N XOR C of the new flags.
- R11: Opcode SWAP=18 exchanges bits 7..4 with bits 3..0 and loads status_in unchanged.
- R12: For every flag-updating opcode, S equals N XOR V.
- R13: status_q resets to 0x00 and loads only on a clock edge with op_en high; otherwise it holds. Bits 7..6 are always copied from status_in.
- R14: Opcodes 19 to 31 are no-ops: result_we stays low and status_in is loaded unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_en | input | 1 | Operation valid this cycle |
| opcode | input | 5 | Operation code |
| opnd_a | input | 8 | First operand (destination value) |
| opnd_b | input | 8 | Second operand (register or immediate) |
| status_in | input | 8 | Current status flags |
| result | output | 8 | Combinational result |
| result_we | output | 1 | Result write strobe |
| status_q | output | 8 | Registered updated status |

## Verification
The bench builds the block with its default 8-bit operand width. At this width the exact boundary operands can be driven directly: 0x7F and 0x80 for signed wrap, 0x00 for negate and borrow, and nibble edges for half-carry. Status inputs are chosen so that a flag an operation must not touch differs from the value the operation would compute. Sticky-zero chaining is exercised with both incoming Z values, and opcodes outside the defined set are exercised as well.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CP   = 5'd4,
        OP_CPC  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSL  = 5'd13,
        OP_ROL  = 5'd14,
        OP_LSR  = 5'd15,
        OP_ROR  = 5'd16,
        OP_ASR  = 5'd17,
        OP_SWAP = 5'd18
    } alu_op_e;

    localparam logic [OP_W-1:0] OP_LAST = 5'd18;

    // bit 0 carry .. bit 7 spare
    typedef struct packed {
        logic x7;
        logic x6;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } status_t;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2,
        BW_NOT = 2'd3
    } bw_sel_e;

    typedef enum logic [2:0] {
        SH_LSL  = 3'd0,
        SH_ROL  = 3'd1,
        SH_LSR  = 3'd2,
        SH_ROR  = 3'd3,
        SH_ASR  = 3'd4,
        SH_SWAP = 3'd5
    } sh_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         c,
    output logic         h,
    output logic         v
);
    localparam int unsigned NIB = W / 2;

    logic [W:0]   full_d;
    logic [NIB:0] low_d;

    always_comb begin
        if (sub) begin
            full_d = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
            low_d  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};
            v      = (a[W-1] ^ b[W-1]) & (full_d[W-1] ^ a[W-1]);
        end else begin
            full_d = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            low_d  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
            v      = ~(a[W-1] ^ b[W-1]) & (full_d[W-1] ^ a[W-1]);
        end
        r = full_d[W-1:0];
        c = full_d[W];
        h = low_d[NIB];
    end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  bw_sel_e      sel,
    output logic [W-1:0] r
);
    always_comb begin
        unique case (sel)
            BW_AND:  r = a & b;
            BW_OR:   r = a | b;
            BW_XOR:  r = a ^ b;
            default: r = ~a;
        endcase
    end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
    import alu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  sh_sel_e      sel,
    output logic [W-1:0] r,
    output logic         c,
    output logic         h
);
    localparam int unsigned NIB = W / 2;

    always_comb begin
        c = a[0];
        h = a[NIB-1];
        unique case (sel)
            SH_LSL: begin r = {a[W-2:0], 1'b0};   c = a[W-1]; end
            SH_ROL: begin r = {a[W-2:0], cin};    c = a[W-1]; end
            SH_LSR:       r = {1'b0, a[W-1:1]};
            SH_ROR:       r = {cin, a[W-1:1]};
            SH_ASR:       r = {a[W-1], a[W-1:1]};
            default:      r = {a[NIB-1:0], a[W-1:NIB]};
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_en,
    input  logic [OP_W-1:0] opcode,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic [7:0]    status_in,
    output logic [W-1:0]  result,
    output logic          result_we,
    output logic [7:0]    status_q
);
    alu_op_e op;
    status_t st_in, st_d, st_q;

    logic [W-1:0] as_a, as_b, as_r, bw_r, sh_r;
    logic         as_cin, as_sub, as_c, as_h, as_v, sh_c, sh_h;
    bw_sel_e      bw_sel;
    sh_sel_e      sh_sel;

    assign op    = alu_op_e'(opcode);
    assign st_in = status_t'(status_in);

    // operand routing for the shared adder/subtractor
    always_comb begin
        as_a   = opnd_a;
        as_b   = opnd_b;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC:          as_cin = st_in.c;
            OP_SUB, OP_CP:   as_sub = 1'b1;
            OP_SBC, OP_CPC: begin as_sub = 1'b1; as_cin = st_in.c; end
            OP_NEG: begin as_a = '0; as_b = opnd_a; as_sub = 1'b1; end
            OP_INC:          as_b = {{(W-1){1'b0}}, 1'b1};
            OP_DEC: begin as_b = {{(W-1){1'b0}}, 1'b1}; as_sub = 1'b1; end
            default: ;
        endcase
    end

    always_comb begin
        case (op)
            OP_AND:  bw_sel = BW_AND;
            OP_OR:   bw_sel = BW_OR;
            OP_XOR:  bw_sel = BW_XOR;
            default: bw_sel = BW_NOT;
        endcase
        case (op)
            OP_LSL:  sh_sel = SH_LSL;
            OP_ROL:  sh_sel = SH_ROL;
            OP_LSR:  sh_sel = SH_LSR;
            OP_ROR:  sh_sel = SH_ROR;
            OP_ASR:  sh_sel = SH_ASR;
            default: sh_sel = SH_SWAP;
        endcase
    end

    alu8_addsub #(.W(W)) u_addsub (
        .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .r(as_r), .c(as_c), .h(as_h), .v(as_v)
    );

    alu8_bitwise #(.W(W)) u_bitwise (
        .a(opnd_a), .b(opnd_b), .sel(bw_sel), .r(bw_r)
    );

    alu8_shifter #(.W(W)) u_shifter (
        .a(opnd_a), .cin(st_in.c), .sel(sh_sel),
        .r(sh_r), .c(sh_c), .h(sh_h)
    );

    // next-state computation
    status_t nxt;
    logic    upd_s;
    logic    is_zero;

    always_comb begin
        nxt       = st_in;
        upd_s     = 1'b1;
        result    = '0;
        result_we = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
                result = as_r;
                nxt.c  = as_c;
                nxt.h  = as_h;
                nxt.v  = as_v;
            end
            OP_INC, OP_DEC: begin
                result = as_r;
                nxt.v  = as_v;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result = bw_r;
                nxt.v  = 1'b0;
            end
            OP_COM: begin
                result = bw_r;
                nxt.v  = 1'b0;
                nxt.c  = 1'b1;
            end
            OP_LSL, OP_ROL: begin
                result = sh_r;
                nxt.c  = sh_c;
                nxt.h  = sh_h;
            end
            OP_LSR, OP_ROR, OP_ASR: begin
                result = sh_r;
                nxt.c  = sh_c;
            end
            OP_SWAP: begin
                result = sh_r;
                upd_s  = 1'b0;
            end
            default: upd_s = 1'b0;
        endcase

        is_zero = (result == '0);
        if (upd_s) begin
            nxt.n = result[W-1];
            nxt.z = (op == OP_SBC || op == OP_CPC) ? (is_zero & st_in.z) : is_zero;
            if (op inside {OP_LSL, OP_ROL, OP_LSR, OP_ROR, OP_ASR})
                nxt.v = nxt.n ^ nxt.c;
            nxt.s = nxt.n ^ nxt.v;
        end

        if (op_en && opcode <= OP_LAST && op != OP_CP && op != OP_CPC)
            result_we = 1'b1;

        st_d = op_en ? nxt : st_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_q = st_q;

    // ---------------- assertions ----------------
    a_r13_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_en |=> $stable(status_q));

    a_r12_sign_is_n_xor_v: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && opcode < OP_SWAP) |=> (status_q[4] == (status_q[2] ^ status_q[3])));

    a_r3_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && (opcode == OP_CP || opcode == OP_CPC)) |-> !result_we);

    a_r5_logic_keeps_c_h: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && opcode >= OP_AND && opcode <= OP_XOR) |=>
        (status_q[0] == $past(status_in[0]) && status_q[5] == $past(status_in[5])));

    a_r7_incdec_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && (opcode == OP_INC || opcode == OP_DEC)) |=>
        (status_q[0] == $past(status_in[0])));

    a_r11_swap_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && opcode == OP_SWAP) |=> (status_q == $past(status_in)));

    a_r14_undefined_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && opcode > OP_LAST) |-> !result_we);

endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;
    import alu8_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_en = 1'b0;
    logic [4:0] opcode = '0;
    logic [7:0] opnd_a = '0, opnd_b = '0, status_in = '0;
    logic [7:0] result, status_q;
    logic       result_we;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    alu8_core uut (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .opcode(opcode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .status_in(status_in),
        .result(result), .result_we(result_we), .status_q(status_q)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    // one operation: result checked mid-cycle, status after the edge
    task automatic run(input string tag, input logic [4:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] sin, input bit chk_res,
                       input logic [7:0] exp_r, input logic exp_we, input logic [7:0] exp_st);
        @(negedge clk);
        op_en = 1'b1; opcode = op; opnd_a = a; opnd_b = b; status_in = sin;
        #1;
        if (chk_res) chk({tag, " result"}, result, exp_r);
        chk({tag, " we"}, {7'd0, result_we}, {7'd0, exp_we});
        @(posedge clk); #1;
        chk({tag, " status"}, status_q, exp_st);
        op_en = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        chk("R13 reset status", status_q, 8'h00);
        chk("R13 reset we", {7'd0, result_we}, 8'h00);
    endtask

    task automatic t_add;
        run("R1 add hc", OP_ADD, 8'h38, 8'h08, 8'h00, 1, 8'h40, 1, 8'h20);
        run("R1 add ovf", OP_ADD, 8'h7F, 8'h01, 8'h00, 1, 8'h80, 1, 8'h2C);
        run("R1 adc wrap", OP_ADC, 8'hFF, 8'h00, 8'h01, 1, 8'h00, 1, 8'h23);
        run("R13 upper bits", OP_ADD, 8'h38, 8'h08, 8'hC0, 1, 8'h40, 1, 8'hE0);
    endtask

    task automatic t_sub;
        run("R2 sub hb", OP_SUB, 8'h10, 8'h01, 8'h00, 1, 8'h0F, 1, 8'h20);
        run("R2 sub borrow", OP_SUB, 8'h00, 8'h01, 8'h00, 1, 8'hFF, 1, 8'h35);
        run("R12 sub ovf", OP_SUB, 8'h80, 8'h01, 8'h00, 1, 8'h7F, 1, 8'h38);
    endtask

    task automatic t_compare;
        run("R3 cp equal", OP_CP, 8'h05, 8'h05, 8'h00, 0, 8'h00, 0, 8'h02);
        run("R4 cpc z low", OP_CPC, 8'h00, 8'h00, 8'h00, 0, 8'h00, 0, 8'h00);
        run("R4 sbc z kept", OP_SBC, 8'h00, 8'h00, 8'h02, 1, 8'h00, 1, 8'h02);
        run("R4 sbc carry", OP_SBC, 8'h05, 8'h04, 8'h03, 1, 8'h00, 1, 8'h02);
        run("R4 sbc nonzero", OP_SBC, 8'h05, 8'h01, 8'h02, 1, 8'h04, 1, 8'h00);
    endtask

    task automatic t_logic;
        run("R5 and", OP_AND, 8'hF0, 8'h80, 8'h29, 1, 8'h80, 1, 8'h35);
        run("R5 xor", OP_XOR, 8'h5A, 8'h5A, 8'h00, 1, 8'h00, 1, 8'h02);
        run("R5 or", OP_OR, 8'h01, 8'h02, 8'h21, 1, 8'h03, 1, 8'h21);
    endtask

    task automatic t_complement;
        run("R6 com", OP_COM, 8'h0F, 8'h00, 8'h20, 1, 8'hF0, 1, 8'h35);
        run("R6 neg one", OP_NEG, 8'h01, 8'h00, 8'h00, 1, 8'hFF, 1, 8'h35);
        run("R6 neg min", OP_NEG, 8'h80, 8'h00, 8'h00, 1, 8'h80, 1, 8'h0D);
        run("R6 neg zero", OP_NEG, 8'h00, 8'h00, 8'h21, 1, 8'h00, 1, 8'h02);
    endtask

    task automatic t_incdec;
        run("R7 inc wrap", OP_INC, 8'h7F, 8'h00, 8'h21, 1, 8'h80, 1, 8'h2D);
        run("R7 dec wrap", OP_DEC, 8'h80, 8'h00, 8'h00, 1, 8'h7F, 1, 8'h18);
        run("R7 dec zero", OP_DEC, 8'h01, 8'h00, 8'h01, 1, 8'h00, 1, 8'h03);
    endtask

    task automatic t_shift;
        run("R8 lsl", OP_LSL, 8'h88, 8'h00, 8'h00, 1, 8'h10, 1, 8'h39);
        run("R8 rol", OP_ROL, 8'h40, 8'h00, 8'h01, 1, 8'h81, 1, 8'h0C);
        run("R9 lsr", OP_LSR, 8'h01, 8'h00, 8'h20, 1, 8'h00, 1, 8'h3B);
        run("R9 ror", OP_ROR, 8'h02, 8'h00, 8'h01, 1, 8'h81, 1, 8'h0C);
        run("R10 asr", OP_ASR, 8'h81, 8'h00, 8'h00, 1, 8'hC0, 1, 8'h15);
    endtask

    task automatic t_swap_undef;
        run("R11 swap", OP_SWAP, 8'hA5, 8'h00, 8'hFF, 1, 8'h5A, 1, 8'hFF);
        run("R14 undefined", 5'd31, 8'h12, 8'h34, 8'h2A, 0, 8'h00, 0, 8'h2A);
    endtask

    task automatic t_hold;
        @(negedge clk);
        op_en = 1'b0; opcode = OP_ADD; opnd_a = 8'hFF; opnd_b = 8'h01; status_in = 8'h00;
        #1;
        chk("R13 idle we", {7'd0, result_we}, 8'h00);
        @(posedge clk); #1;
        chk("R13 hold", status_q, 8'h2A);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_compare();
        t_logic();
        t_complement();
        t_incdec();
        t_shift();
        t_swap_undef();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule